// File: doc/BRIEF.md
# UART Special Character Detector

This block sits on the receive side of a UART, just after the deserializer. Each time a completed character arrives, it forwards the character to the receive FIFO write port. While detection is enabled, it also compares the character against a programmable special-character value. A match sets a sticky status flag. That flag drives an interrupt request when the interrupt enable is high. The matching character is not removed from the data stream: it reaches the FIFO exactly like any other character.

The comparison covers only the active word length, which is 5, 6, 7 or 8 bits as selected by a two-bit code. Compare-register bits and received bits above that length take no part in the comparison. The detection mode is meant to be used with software flow control switched off. If any of the four flow-control mode bits is set while detection is enabled, the block still compares, and it raises a configuration warning. A character flagged with a framing error is stored but never compared. The host clears the flag by reading its interrupt status, which the block sees as a one-cycle read strobe.

Top module: `uart_spchar_detect`

## Requirements
- R1: A character can set the special-character status only while `spc_en` is 1. With `spc_en` at 0, no character sets it.
- R2: Every cycle with `rx_valid` high produces `fifo_wr` high in the following cycle. `fifo_wdata` then holds `rx_data` with the bits above the word length cleared. A cycle without `rx_valid` gives `fifo_wr` low in the next cycle.
- R3: A matching character sets `spc_status` in the cycle after it is presented.
- R4: `wlen` selects the compare width: 00 selects 5 bits, 01 selects 6, 10 selects 7 and 11 selects 8. Bit 0 of `spc_char` is compared with bit 0 of `rx_data`.
- R5: Bits of `spc_char` and of `rx_data` at or above the selected width are ignored by the comparison.
- R6: `spc_status` stays set until an `isr_read` pulse, and it reads 0 in the cycle after that pulse. If a match arrives in the same cycle as the read, the flag stays set.
- R7: `spc_irq` is `spc_status` gated by `spc_irq_en`, updated one clock after either of them changes. It is never high while `spc_status` is low.
- R8: `cfg_warn` is 1 in the cycle after a cycle in which `spc_en` is 1 and `swfc_mode` is nonzero, and 0 otherwise. The comparison is carried out either way.
- R9: A character with `rx_frame_err` high is still written to the FIFO, but it never sets `spc_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe marking a completed received character |
| rx_data | input | 8 | Received character, LSB in bit 0 |
| rx_frame_err | input | 1 | Framing error for the character on `rx_data` |
| wlen | input | 2 | Word length code (00=5 … 11=8 bits) |
| spc_en | input | 1 | Special-character detection enable |
| swfc_mode | input | 4 | Software flow-control mode bits |
| spc_char | input | 8 | Special-character compare value |
| spc_irq_en | input | 1 | Interrupt enable for the detection flag |
| isr_read | input | 1 | Host read of the interrupt status; clears the flag |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | 8 | Receive FIFO write data |
| spc_status | output | 1 | Sticky special-character detected flag |
| spc_irq | output | 1 | Interrupt request |
| cfg_warn | output | 1 | Detection enabled while software flow control is on |

## Verification
Several properties are checked on every cycle:
- a valid character always produces a FIFO write one cycle later;
- the flag holds until a read;
- a read with no competing match clears the flag;
- the flag cannot rise while detection is disabled or on a framing-errored character;
- the interrupt follows its enable;
- a nonzero mode with detection enabled always raises the warning.

Whether a given character actually matches under each word length can only be shown by the bench's scenarios. The same holds for the masking of high bits, for the FIFO data values and for the match-during-read race.

// File: rtl/spchar_pkg.sv
package spchar_pkg;
  typedef enum logic [1:0] {
    WL_5 = 2'b00,
    WL_6 = 2'b01,
    WL_7 = 2'b10,
    WL_8 = 2'b11
  } wlen_e;

  localparam int MIN_CHAR_BITS = 5;

  function automatic int active_bits(input wlen_e code);
    return MIN_CHAR_BITS + int'(code);
  endfunction
endpackage

// File: rtl/spchar_mask.sv
module spchar_mask #(
  parameter int DATA_W = 8,
  parameter int WLEN_W = 2
) (
  input  logic [WLEN_W-1:0] wlen,
  output logic [DATA_W-1:0] mask
);
  import spchar_pkg::*;

  int nbits;
  always_comb nbits = active_bits(wlen_e'(wlen));

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign mask[g] = (g < nbits);
  end
endmodule

// File: rtl/spchar_cmp.sv
module spchar_cmp #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_frame_err,
  input  logic              spc_en,
  input  logic [DATA_W-1:0] spc_char,
  input  logic [DATA_W-1:0] mask,
  output logic              hit,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata
);
  logic [DATA_W-1:0] diff;

  always_comb begin
    diff = (rx_data ^ spc_char) & mask;
    hit  = rx_valid && spc_en && !rx_frame_err && (diff == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_wr    <= 1'b0;
      fifo_wdata <= '0;
    end else begin
      fifo_wr <= rx_valid;
      if (rx_valid) fifo_wdata <= rx_data & mask;
    end
  end

  assert_fifo_write_R2: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> fifo_wr);
  assert_no_spurious_write_R2: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !fifo_wr);
endmodule

// File: rtl/spchar_status.sv
module spchar_status (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en,
  output logic flag_q,
  output logic irq_q
);
  logic flag_next;

  always_comb flag_next = set_i | (flag_q & ~clr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_next;
      irq_q  <= flag_next & irq_en;
    end
  end

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_i) |=> flag_q);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq_q);
  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
endmodule

// File: rtl/spchar_cfgchk.sv
module spchar_cfgchk #(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spc_en,
  input  logic [MODE_W-1:0] swfc_mode,
  output logic              warn_q
);
  always_ff @(posedge clk) begin
    if (rst) warn_q <= 1'b0;
    else     warn_q <= spc_en && (|swfc_mode);
  end

  assert_warn_raised_R8: assert property (@(posedge clk) disable iff (rst)
    (spc_en && swfc_mode != '0) |=> warn_q);
  assert_warn_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !spc_en |=> !warn_q);
endmodule

// File: rtl/uart_spchar_detect.sv
module uart_spchar_detect #(
  parameter int DATA_W = 8,
  parameter int WLEN_W = 2,
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_frame_err,
  input  logic [WLEN_W-1:0] wlen,
  input  logic              spc_en,
  input  logic [MODE_W-1:0] swfc_mode,
  input  logic [DATA_W-1:0] spc_char,
  input  logic              spc_irq_en,
  input  logic              isr_read,
  output logic              fifo_wr,
  output logic [DATA_W-1:0] fifo_wdata,
  output logic              spc_status,
  output logic              spc_irq,
  output logic              cfg_warn
);
  logic [DATA_W-1:0] mask;
  logic              hit;

  spchar_mask #(.DATA_W(DATA_W), .WLEN_W(WLEN_W)) u_mask (
    .wlen (wlen),
    .mask (mask)
  );

  spchar_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk          (clk),
    .rst          (rst),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_frame_err (rx_frame_err),
    .spc_en       (spc_en),
    .spc_char     (spc_char),
    .mask         (mask),
    .hit          (hit),
    .fifo_wr      (fifo_wr),
    .fifo_wdata   (fifo_wdata)
  );

  spchar_status u_status (
    .clk    (clk),
    .rst    (rst),
    .set_i  (hit),
    .clr_i  (isr_read),
    .irq_en (spc_irq_en),
    .flag_q (spc_status),
    .irq_q  (spc_irq)
  );

  spchar_cfgchk #(.MODE_W(MODE_W)) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .spc_en    (spc_en),
    .swfc_mode (swfc_mode),
    .warn_q    (cfg_warn)
  );

  assert_no_set_disabled_R1: assert property (@(posedge clk) disable iff (rst)
    (!spc_en && !spc_status) |=> !spc_status);
  assert_no_set_on_frame_err_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_frame_err && !spc_status) |=> !spc_status);
endmodule

// File: tb/sim_uart_spchar_detect.sv
module sim_uart_spchar_detect;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_frame_err = 1'b0;
  logic [1:0] wlen = 2'b11;
  logic       spc_en = 1'b0;
  logic [3:0] swfc_mode = '0;
  logic [7:0] spc_char = '0;
  logic       spc_irq_en = 1'b0;
  logic       isr_read = 1'b0;
  logic       fifo_wr;
  logic [7:0] fifo_wdata;
  logic       spc_status;
  logic       spc_irq;
  logic       cfg_warn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_spchar_detect u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_frame_err(rx_frame_err), .wlen(wlen), .spc_en(spc_en),
    .swfc_mode(swfc_mode), .spc_char(spc_char), .spc_irq_en(spc_irq_en),
    .isr_read(isr_read), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
    .spc_status(spc_status), .spc_irq(spc_irq), .cfg_warn(cfg_warn)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] wl_mask(input logic [1:0] w);
    return 8'((9'd1 << (5 + w)) - 9'd1);
  endfunction

  task automatic send(input logic [7:0] d, input logic fe);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_frame_err = fe;
    @(negedge clk);
    rx_valid = 1'b0; rx_frame_err = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk);
    isr_read = 1'b1;
    @(negedge clk);
    isr_read = 1'b0;
  endtask

  task automatic t_reset();
    check("R2", "fifo_wr after reset", fifo_wr, 0);
    check("R3", "status after reset", spc_status, 0);
    check("R7", "irq after reset", spc_irq, 0);
    check("R8", "warn after reset", cfg_warn, 0);
  endtask

  task automatic t_disabled();
    spc_en = 1'b0; wlen = 2'b11; spc_char = 8'hA5;
    send(8'hA5, 1'b0);
    check("R2", "write while disabled", fifo_wr, 1);
    check("R1", "no detection while disabled", spc_status, 0);
    @(negedge clk);
    check("R2", "no write without valid", fifo_wr, 0);
  endtask

  task automatic t_match8();
    spc_en = 1'b1; spc_irq_en = 1'b1; wlen = 2'b11; spc_char = 8'hA5;
    send(8'hA4, 1'b0);
    check("R4", "8-bit mismatch", spc_status, 0);
    send(8'hA5, 1'b0);
    check("R3", "8-bit match sets status", spc_status, 1);
    check("R2", "match still written", fifo_wr, 1);
    check("R2", "match data", fifo_wdata, 8'hA5);
    check("R7", "irq with enable", spc_irq, 1);
    repeat (3) @(negedge clk);
    check("R6", "status sticky", spc_status, 1);
    host_read();
    check("R6", "read clears status", spc_status, 0);
    check("R7", "read drops irq", spc_irq, 0);
  endtask

  task automatic t_widths();
    spc_en = 1'b1; spc_irq_en = 1'b0;
    wlen = 2'b00; spc_char = 8'hE3;
    send(8'h23, 1'b0);
    check("R5", "5-bit match ignores high bits", spc_status, 1);
    check("R2", "5-bit data masked", fifo_wdata, 8'h23 & wl_mask(2'b00));
    host_read();
    send(8'h13, 1'b0);
    check("R4", "5-bit mismatch in bit 4", spc_status, 0);
    wlen = 2'b01; spc_char = 8'h2A;
    send(8'hEA, 1'b0);
    check("R4", "6-bit match", spc_status, 1);
    check("R2", "6-bit data masked", fifo_wdata, 8'hEA & wl_mask(2'b01));
    host_read();
    wlen = 2'b10; spc_char = 8'h7F;
    send(8'hFF, 1'b0);
    check("R5", "7-bit match ignores bit 7", spc_status, 1);
    check("R2", "7-bit data masked", fifo_wdata, 8'h7F);
    host_read();
    send(8'h3F, 1'b0);
    check("R4", "7-bit mismatch in bit 6", spc_status, 0);
    send(8'h7E, 1'b0);
    check("R4", "bit 0 aligned to LSB", spc_status, 0);
  endtask

  task automatic t_irq_gate();
    spc_en = 1'b1; spc_irq_en = 1'b0; wlen = 2'b11; spc_char = 8'h11;
    send(8'h11, 1'b0);
    check("R3", "status set with irq off", spc_status, 1);
    check("R7", "irq gated off", spc_irq, 0);
    spc_irq_en = 1'b1;
    @(negedge clk);
    check("R7", "irq follows enable", spc_irq, 1);
    spc_irq_en = 1'b0;
    @(negedge clk);
    check("R7", "irq drops with enable", spc_irq, 0);
    host_read();
  endtask

  task automatic t_race();
    spc_en = 1'b1; wlen = 2'b11; spc_char = 8'h5A;
    send(8'h5A, 1'b0);
    check("R3", "status before race", spc_status, 1);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h5A; isr_read = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; isr_read = 1'b0;
    check("R6", "match during read keeps flag", spc_status, 1);
    host_read();
    check("R6", "later read clears", spc_status, 0);
  endtask

  task automatic t_warn();
    spc_en = 1'b1; swfc_mode = 4'b0010; wlen = 2'b11; spc_char = 8'h33;
    @(negedge clk);
    check("R8", "warn with mode set", cfg_warn, 1);
    send(8'h33, 1'b0);
    check("R8", "compare still runs with warn", spc_status, 1);
    host_read();
    swfc_mode = 4'b0000;
    @(negedge clk);
    check("R8", "warn off with mode clear", cfg_warn, 0);
    spc_en = 1'b0; swfc_mode = 4'b1000;
    @(negedge clk);
    check("R8", "no warn while disabled", cfg_warn, 0);
    swfc_mode = 4'b0000;
  endtask

  task automatic t_frame();
    spc_en = 1'b1; wlen = 2'b11; spc_char = 8'h47;
    send(8'h47, 1'b1);
    check("R9", "framing char written", fifo_wr, 1);
    check("R9", "framing char data", fifo_wdata, 8'h47);
    check("R9", "framing char not compared", spc_status, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_match8();
    t_widths();
    t_irq_gate();
    t_race();
    t_warn();
    t_frame();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule